// File: doc/BRIEF.md
# Bilinear Footprint Texel Cache

This block is a read-only texel store placed between a texture filtering unit and the next memory level. The filter sends integer texel coordinates (x, y). The cache answers with the four texels of the 2x2 bilinear footprint anchored at that point, all in one response beat, so a bilinear filter can take one footprint per cycle. Texel data enters only through line fills from the next level. Each line holds one square tile of texels, so a footprint touches between one and four lines.

Requests wait in an in-order queue. The queue head is looked up against a direct-mapped tag array. If every tile it touches is resident, the footprint is read through four parallel ports and returned. Otherwise the missing tiles are fetched one at a time over a request/response memory port, and the head is looked up again. Later requests, including hits, wait behind it, so responses always leave in request order. Before the texture is rendered to, a flush clears every line. The flush is taken only while no fill is in progress.

Top module: `texel_cache`

## Requirements
- R1: Each response carries four 32-bit texels. Field k sits at bits [32k+31:32k], and k = 0..3 selects texels (x,y), (x+1,y), (x,y+1) and (x+1,y+1). Coordinates wrap modulo the texture size of 2^COORD_W.
- R2: A line is one 2^TILE_LOG2-square tile. A miss requests tile id {ty, tx}, where tx = x >> TILE_LOG2 is in the low half and ty is in the high half. The memory answers with 2^TILE_LOG2 beats carrying rows 0, 1, ... in order, and texel column j of a row sits at bits [32j+31:32j].
- R3: A request is a hit only when every tile it touches is resident. Each missing tile is fetched exactly once for that request. A request whose tiles are all resident causes no fetch and returns the stored data.
- R4: Responses leave in request order. A hit queued behind a pending miss is not answered before that miss.
- R5: The request queue holds 2^QDEPTH_LOG2 entries. `in_ready` is low exactly while the queue is full.
- R6: `flush_ready` is low while a fill is requested or in progress. An accepted flush invalidates all lines, so the next request for a previously resident tile fetches it again.
- R7: `mem_req_valid` stays high with a stable `mem_req_tile` until `mem_req_ready`, and only one fill is outstanding at a time.
- R8: After reset no line is valid, `rsp_valid` and `mem_req_valid` are low, and `in_ready` and `flush_ready` are high.
- R9: The cache is direct-mapped. The line index is {ty low bits, tx low bits} (LINES_LOG2/2 bits each), so two tiles with the same index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Footprint request valid |
| in_ready | output | 1 | Request queue can accept |
| in_x | input | COORD_W | Footprint anchor x |
| in_y | input | COORD_W | Footprint anchor y |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_texels | output | 4*TEXEL_W | Four footprint texels |
| flush_valid | input | 1 | Invalidate all lines |
| flush_ready | output | 1 | Flush can be taken this cycle |
| mem_req_valid | output | 1 | Tile fetch request |
| mem_req_ready | input | 1 | Next level takes the fetch |
| mem_req_tile | output | 2*(COORD_W-TILE_LOG2) | Tile id {ty, tx} |
| mem_rsp_valid | input | 1 | Fill row beat valid |
| mem_rsp_row | input | 2^TILE_LOG2*TEXEL_W | One tile row of texels |

## Verification
The bench checks footprints that sit inside one tile and footprints that cross the x, y and diagonal tile seams, including the wrap at the texture corner. A design that decodes tiles wrongly would return texels from the wrong place, and one that refetched resident tiles would show extra fetches. It sends a hit directly behind a long miss and checks that neither is answered early; a design that let hits bypass would fail the in-order data comparison. It changes the memory contents without a flush to prove that resident data is reused, then flushes to prove it is refetched. It also fills the queue while the memory stalls and evicts one tile with another tile that maps to the same index.

// File: rtl/texel_cache_pkg.sv
package texel_cache_pkg;
   typedef enum logic [1:0] {
      FILL_IDLE,
      FILL_ASK,
      FILL_RECV
   } fill_state_t;

   localparam int unsigned CORNERS = 4;
endpackage

// File: rtl/texel_cache_queue.sv
module texel_cache_queue #(
   parameter int unsigned WIDTH       = 12,
   parameter int unsigned DEPTH_LOG2  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int unsigned DEPTH = 1 << DEPTH_LOG2;

   logic [WIDTH-1:0]      slots [DEPTH];
   logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
   logic [DEPTH_LOG2:0]   count;

   assign empty = (count == '0);
   assign full  = (count == (DEPTH_LOG2+1)'(DEPTH));
   assign dout  = slots[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + (DEPTH_LOG2+1)'(push) - (DEPTH_LOG2+1)'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= din;
   end
endmodule

// File: rtl/texel_cache_tags.sv
module texel_cache_tags #(
   parameter int unsigned LINES_LOG2 = 4,
   parameter int unsigned TAG_W      = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [3:0][LINES_LOG2-1:0] lk_idx,
   input  logic [3:0][TAG_W-1:0]      lk_tag,
   output logic [3:0]                 hit,
   input  logic                       set_en,
   input  logic [LINES_LOG2-1:0]      set_idx,
   input  logic [TAG_W-1:0]           set_tag,
   input  logic                       flush
);
   localparam int unsigned LINES = 1 << LINES_LOG2;

   logic [LINES-1:0] line_ok;
   logic [TAG_W-1:0] line_tag [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n)      line_ok <= '0;
      else if (flush)  line_ok <= '0;
      else if (set_en) line_ok[set_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (set_en) line_tag[set_idx] <= set_tag;
   end

   for (genvar k = 0; k < 4; k++) begin : g_port
      assign hit[k] = line_ok[lk_idx[k]] && (line_tag[lk_idx[k]] == lk_tag[k]);
   end
endmodule

// File: rtl/texel_cache_data.sv
module texel_cache_data #(
   parameter int unsigned LINES_LOG2 = 4,
   parameter int unsigned TILE_LOG2  = 3,
   parameter int unsigned TEXEL_W    = 32
) (
   input  logic                                     clk,
   input  logic                                     wr_en,
   input  logic [LINES_LOG2+TILE_LOG2-1:0]          wr_base,
   input  logic [(1<<TILE_LOG2)*TEXEL_W-1:0]        wr_row,
   input  logic [3:0][LINES_LOG2+2*TILE_LOG2-1:0]   rd_addr,
   output logic [3:0][TEXEL_W-1:0]                  rd_data
);
   localparam int unsigned TILE   = 1 << TILE_LOG2;
   localparam int unsigned ADDR_W = LINES_LOG2 + 2*TILE_LOG2;
   localparam int unsigned WORDS  = 1 << ADDR_W;

   logic [TEXEL_W-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int j = 0; j < TILE; j++) begin
            store[{wr_base, TILE_LOG2'(j)}] <= wr_row[j*TEXEL_W +: TEXEL_W];
         end
      end
   end

   for (genvar k = 0; k < 4; k++) begin : g_rd
      assign rd_data[k] = store[rd_addr[k]];
   end
endmodule

// File: rtl/texel_cache_fill.sv
module texel_cache_fill
   import texel_cache_pkg::*;
#(
   parameter int unsigned TILE_LOG2 = 3,
   parameter int unsigned TID_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [TID_W-1:0]     start_tile,
   output logic                 busy,
   output logic [TID_W-1:0]     cur_tile,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   input  logic                 mem_rsp_valid,
   output logic                 wr_en,
   output logic [TILE_LOG2-1:0] wr_row,
   output logic                 done
);
   localparam logic [TILE_LOG2-1:0] LAST_ROW = '1;

   fill_state_t state;

   assign busy          = (state != FILL_IDLE);
   assign mem_req_valid = (state == FILL_ASK);
   assign wr_en         = (state == FILL_RECV) && mem_rsp_valid;
   assign done          = wr_en && (wr_row == LAST_ROW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= FILL_IDLE;
         wr_row   <= '0;
         cur_tile <= '0;
      end else begin
         unique case (state)
            FILL_IDLE: if (start) begin
               cur_tile <= start_tile;
               state    <= FILL_ASK;
            end
            FILL_ASK: if (mem_req_ready) begin
               wr_row <= '0;
               state  <= FILL_RECV;
            end
            FILL_RECV: if (mem_rsp_valid) begin
               wr_row <= wr_row + 1'b1;
               if (wr_row == LAST_ROW) state <= FILL_IDLE;
            end
            default: state <= FILL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/texel_cache.sv
module texel_cache #(
   parameter int unsigned COORD_W     = 6,
   parameter int unsigned TILE_LOG2   = 3,
   parameter int unsigned LINES_LOG2  = 4,
   parameter int unsigned TEXEL_W     = 32,
   parameter int unsigned QDEPTH_LOG2 = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   output logic                                  in_ready,
   input  logic [COORD_W-1:0]                    in_x,
   input  logic [COORD_W-1:0]                    in_y,
   output logic                                  rsp_valid,
   output logic [4*TEXEL_W-1:0]                  rsp_texels,
   input  logic                                  flush_valid,
   output logic                                  flush_ready,
   output logic                                  mem_req_valid,
   input  logic                                  mem_req_ready,
   output logic [2*(COORD_W-TILE_LOG2)-1:0]      mem_req_tile,
   input  logic                                  mem_rsp_valid,
   input  logic [(1<<TILE_LOG2)*TEXEL_W-1:0]     mem_rsp_row
);
   localparam int unsigned TC_W   = COORD_W - TILE_LOG2;
   localparam int unsigned HALF   = LINES_LOG2 / 2;
   localparam int unsigned TAG_W  = 2 * (TC_W - HALF);
   localparam int unsigned TID_W  = 2 * TC_W;
   localparam int unsigned ADDR_W = LINES_LOG2 + 2*TILE_LOG2;

   if (LINES_LOG2 % 2 != 0 || LINES_LOG2 < 2) begin : g_bad_lines
      $error("LINES_LOG2 must be even and at least 2");
   end
   if (HALF >= TC_W) begin : g_bad_tiles
      $error("texture must hold more tile columns than index bits per axis");
   end
   if (TILE_LOG2 < 1 || TEXEL_W < 1) begin : g_bad_tile
      $error("tile and texel sizes must be nonzero");
   end

   logic                 q_empty, q_full, q_pop;
   logic [COORD_W-1:0]   hx, hy;
   logic [3:0]           hit;
   logic [3:0][LINES_LOG2-1:0] c_idx;
   logic [3:0][TAG_W-1:0]      c_tag;
   logic [3:0][TID_W-1:0]      c_tid;
   logic [3:0][ADDR_W-1:0]     c_addr;
   logic [3:0][TEXEL_W-1:0]    rd_data;
   logic [TID_W-1:0]     miss_tid, cur_tile;
   logic                 fill_busy, fill_start, wr_en, fill_done, lookup_ok, flush_go;
   logic [TILE_LOG2-1:0] wr_row;
   logic [TC_W-1:0]      f_tx, f_ty;

   assign in_ready = !q_full;

   texel_cache_queue #(.WIDTH(2*COORD_W), .DEPTH_LOG2(QDEPTH_LOG2)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid && !q_full), .din({in_y, in_x}),
      .pop(q_pop), .dout({hy, hx}),
      .empty(q_empty), .full(q_full)
   );

   // corner k: x offset k[0], y offset k[1]; wrap by truncation
   for (genvar k = 0; k < 4; k++) begin : g_corner
      logic [COORD_W-1:0] cx, cy;
      logic [TC_W-1:0]    tx, ty;
      assign cx = hx + COORD_W'(k & 1);
      assign cy = hy + COORD_W'(k >> 1);
      assign tx = cx[COORD_W-1:TILE_LOG2];
      assign ty = cy[COORD_W-1:TILE_LOG2];
      assign c_idx[k]  = {ty[HALF-1:0], tx[HALF-1:0]};
      assign c_tag[k]  = {ty[TC_W-1:HALF], tx[TC_W-1:HALF]};
      assign c_tid[k]  = {ty, tx};
      assign c_addr[k] = {c_idx[k], cy[TILE_LOG2-1:0], cx[TILE_LOG2-1:0]};
   end

   always_comb begin
      miss_tid = c_tid[3];
      for (int k = 3; k >= 0; k--) begin
         if (!hit[k]) miss_tid = c_tid[k];
      end
   end

   assign lookup_ok   = !q_empty && !fill_busy;
   assign q_pop       = lookup_ok && (&hit);
   assign fill_start  = lookup_ok && !(&hit);
   assign flush_ready = !fill_busy;
   assign flush_go    = flush_valid && flush_ready;
   assign f_tx        = cur_tile[TC_W-1:0];
   assign f_ty        = cur_tile[TID_W-1:TC_W];

   texel_cache_tags #(.LINES_LOG2(LINES_LOG2), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(c_idx), .lk_tag(c_tag), .hit(hit),
      .set_en(fill_done),
      .set_idx({f_ty[HALF-1:0], f_tx[HALF-1:0]}),
      .set_tag({f_ty[TC_W-1:HALF], f_tx[TC_W-1:HALF]}),
      .flush(flush_go)
   );

   texel_cache_data #(.LINES_LOG2(LINES_LOG2), .TILE_LOG2(TILE_LOG2), .TEXEL_W(TEXEL_W)) u_data (
      .clk(clk), .wr_en(wr_en),
      .wr_base({f_ty[HALF-1:0], f_tx[HALF-1:0], wr_row}),
      .wr_row(mem_rsp_row),
      .rd_addr(c_addr), .rd_data(rd_data)
   );

   texel_cache_fill #(.TILE_LOG2(TILE_LOG2), .TID_W(TID_W)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .start(fill_start), .start_tile(miss_tid),
      .busy(fill_busy), .cur_tile(cur_tile),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .wr_en(wr_en), .wr_row(wr_row), .done(fill_done)
   );

   assign mem_req_tile = cur_tile;

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= q_pop;
   end

   always_ff @(posedge clk) begin
      if (q_pop) rsp_texels <= rd_data;
   end
endmodule

// File: rtl/texel_cache_chk.sv
module texel_cache_chk #(
   parameter int unsigned COORD_W     = 6,
   parameter int unsigned TILE_LOG2   = 3,
   parameter int unsigned QDEPTH_LOG2 = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             in_valid,
   input logic                             in_ready,
   input logic                             rsp_valid,
   input logic                             flush_valid,
   input logic                             flush_ready,
   input logic                             mem_req_valid,
   input logic                             mem_req_ready,
   input logic [2*(COORD_W-TILE_LOG2)-1:0] mem_req_tile,
   input logic                             mem_rsp_valid
);
   localparam int unsigned DEPTH = 1 << QDEPTH_LOG2;
   localparam int unsigned TILE  = 1 << TILE_LOG2;

   logic [15:0]        pending;
   logic               fill_open;
   logic [TILE_LOG2:0] beats;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending   <= '0;
         fill_open <= 1'b0;
         beats     <= '0;
      end else begin
         pending <= pending + 16'(in_valid && in_ready) - 16'(rsp_valid);
         if (mem_req_valid && mem_req_ready) begin
            fill_open <= 1'b1;
            beats     <= '0;
         end else if (fill_open && mem_rsp_valid) begin
            beats <= beats + 1'b1;
            if (beats == (TILE_LOG2+1)'(TILE - 1)) fill_open <= 1'b0;
         end
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending <= 16'(DEPTH + 1));

   // R5
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> pending >= 16'(DEPTH));

   // R4
   rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> pending != '0);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_tile));

   // R7
   single_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_open |-> !mem_req_valid);

   // R6
   flush_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid && flush_ready |-> !fill_open && !mem_req_valid);
endmodule

bind texel_cache texel_cache_chk #(
   .COORD_W(COORD_W), .TILE_LOG2(TILE_LOG2), .QDEPTH_LOG2(QDEPTH_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .rsp_valid(rsp_valid), .flush_valid(flush_valid), .flush_ready(flush_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_tile(mem_req_tile), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/texel_cache_tb.sv
`timescale 1ns/1ps
module texel_cache_tb;
   localparam int CW = 6, TL = 3, LL = 4, TW = 32, QL = 2;
   localparam int TILE = 1 << TL, DEPTH = 1 << QL;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, flush_valid = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
   logic [CW-1:0] in_x = '0, in_y = '0;
   logic [TILE*TW-1:0] mem_rsp_row = '0;
   logic in_ready, rsp_valid, flush_ready, mem_req_valid;
   logic [4*TW-1:0] rsp_texels;
   logic [2*(CW-TL)-1:0] mem_req_tile;

   always #2.5 clk = ~clk;

   texel_cache #(.COORD_W(CW), .TILE_LOG2(TL), .LINES_LOG2(LL), .TEXEL_W(TW), .QDEPTH_LOG2(QL)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_x(in_x), .in_y(in_y), .rsp_valid(rsp_valid), .rsp_texels(rsp_texels),
      .flush_valid(flush_valid), .flush_ready(flush_ready),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_tile(mem_req_tile), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_row(mem_rsp_row)
   );

   int checks = 0, fails = 0;
   int snd_cnt = 0, rcv_cnt = 0, fetches = 0, last_tile = -1;
   int gen = 0;
   bit hold = 1'b0;
   int exp_x [64], exp_y [64], exp_g [64];

   function automatic logic [31:0] tex(int x, int y, int g);
      return {8'(g), 8'h5A, 8'(y), 8'(x)};
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // next-level memory model, variable latency
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_req_valid && !hold) begin
            int t, tx, ty, d;
            t = int'(mem_req_tile);
            tx = t % (1 << (CW-TL));
            ty = t / (1 << (CW-TL));
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            fetches++;
            last_tile = t;
            d = 5 + (fetches * 7) % 13;
            repeat (d) @(negedge clk);
            for (int r = 0; r < TILE; r++) begin
               mem_rsp_valid = 1'b1;
               for (int j = 0; j < TILE; j++)
                  mem_rsp_row[j*TW +: TW] = tex(tx*TILE + j, ty*TILE + r, gen);
               @(negedge clk);
            end
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // response collector: R1 field order, R4 request order
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (rcv_cnt >= snd_cnt) begin
            chk(1'b0, "R4 response without request", rcv_cnt, snd_cnt);
         end else begin
            for (int k = 0; k < 4; k++) begin
               int ex, ey;
               logic [31:0] e;
               ex = (exp_x[rcv_cnt] + (k & 1)) % (1 << CW);
               ey = (exp_y[rcv_cnt] + (k >> 1)) % (1 << CW);
               e = tex(ex, ey, exp_g[rcv_cnt]);
               chk(rsp_texels[k*TW +: TW] === e, "R1/R4 texel", int'(rsp_texels[k*TW +: TW]), int'(e));
            end
         end
         rcv_cnt++;
      end
   end

   task automatic send(int x, int y, int g);
      exp_x[snd_cnt] = x; exp_y[snd_cnt] = y; exp_g[snd_cnt] = g;
      snd_cnt++;
      @(negedge clk);
      in_valid = 1'b1; in_x = CW'(x); in_y = CW'(y);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while (rcv_cnt != snd_cnt && n < 2000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      chk(rcv_cnt == snd_cnt, "R4 drain", rcv_cnt, snd_cnt);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R8 rsp_valid", int'(rsp_valid), 0);
      chk(mem_req_valid == 1'b0, "R8 mem_req_valid", int'(mem_req_valid), 0);
      chk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
      chk(flush_ready == 1'b1, "R8 flush_ready", int'(flush_ready), 1);
   endtask

   task automatic t_single();
      int f0 = fetches;
      send(2, 3, 0); drain();
      chk(fetches - f0 == 1, "R3 cold fetch count", fetches - f0, 1);
      chk(last_tile == 0, "R2 tile id", last_tile, 0);
      f0 = fetches;
      send(5, 6, 0); drain();
      chk(fetches - f0 == 0, "R3 resident tile refetched", fetches - f0, 0);
   endtask

   task automatic t_span();
      int f0 = fetches;
      send(7, 7, 0); drain();
      chk(fetches - f0 == 3, "R3 diagonal seam fetches", fetches - f0, 3);
      f0 = fetches;
      send(8, 7, 0); drain();
      chk(fetches - f0 == 0, "R3 seam all resident", fetches - f0, 0);
   endtask

   task automatic t_wrap();
      int f0 = fetches;
      send(63, 63, 0); drain();
      chk(fetches - f0 == 3, "R1 wrap corner fetches", fetches - f0, 3);
   endtask

   task automatic t_inorder();
      int f0 = fetches;
      send(40, 8, 0);
      send(1, 1, 0);
      chk(rcv_cnt == snd_cnt - 2, "R4 hit waits behind miss", rcv_cnt, snd_cnt - 2);
      drain();
      chk(fetches - f0 == 1, "R3 hit behind miss fetches", fetches - f0, 1);
      chk(last_tile == 13, "R2 tile id {ty,tx}", last_tile, 13);
   endtask

   task automatic t_full();
      int f0 = fetches;
      logic [5:0] t0;
      hold = 1'b1;
      send(16, 16, 0); send(24, 16, 0); send(16, 24, 0); send(48, 48, 0);
      @(negedge clk);
      chk(in_ready == 1'b0, "R5 full queue stalls", int'(in_ready), 0);
      chk(mem_req_valid == 1'b1, "R7 request raised", int'(mem_req_valid), 1);
      chk(mem_req_tile == 6'd18, "R2 stalled tile id", int'(mem_req_tile), 18);
      chk(flush_ready == 1'b0, "R6 flush blocked during fill", int'(flush_ready), 0);
      t0 = mem_req_tile;
      repeat (5) @(negedge clk);
      chk(mem_req_valid == 1'b1 && mem_req_tile == t0, "R7 request held", int'(mem_req_tile), int'(t0));
      hold = 1'b0;
      drain();
      chk(fetches - f0 == 4, "R3 queued miss fetches", fetches - f0, 4);
      chk(in_ready == 1'b1, "R5 ready after drain", int'(in_ready), 1);
   endtask

   task automatic t_conflict();
      int f0 = fetches;
      send(1, 1, 0); drain();
      chk(fetches - f0 == 0, "R9 tile 0 still resident", fetches - f0, 0);
      f0 = fetches;
      send(33, 1, 0); drain();
      chk(fetches - f0 == 1, "R9 aliasing tile fetched", fetches - f0, 1);
      f0 = fetches;
      send(1, 1, 0); drain();
      chk(fetches - f0 == 1, "R9 evicted tile refetched", fetches - f0, 1);
   endtask

   task automatic t_flush();
      int f0 = fetches;
      gen = 1;
      send(2, 2, 0); drain();
      chk(fetches - f0 == 0, "R3 stale data kept without flush", fetches - f0, 0);
      @(negedge clk);
      chk(flush_ready == 1'b1, "R6 flush ready when idle", int'(flush_ready), 1);
      flush_valid = 1'b1;
      @(negedge clk);
      flush_valid = 1'b0;
      f0 = fetches;
      send(2, 2, 1); drain();
      chk(fetches - f0 == 1, "R6 refetch after flush", fetches - f0, 1);
      f0 = fetches;
      send(40, 9, 1); drain();
      chk(fetches - f0 == 1, "R6 other line invalidated", fetches - f0, 1);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_span();
      t_wrap();
      t_inorder();
      t_full();
      t_conflict();
      t_flush();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", rcv_cnt, snd_cnt);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule